// File: doc/BRIEF.md
# SPI Toggle-Bit Watchdog

This block checks that a host is still talking to the chip over its serial port. It is armed by a rising edge on an asynchronous wake/reset pin. From then on it looks at the most significant bit of every completed 16-bit frame, whatever register the frame addresses. The host is expected to flip that bit from one frame to the next.

Each flip restarts a timeout counter that runs on the system clock. If no flip arrives before the counter runs out, the block raises a fail-safe request. That request stays raised until the wake pin is pulled low again. While the pin is low, the block sleeps: all of its state is cleared and frames are ignored.

The serial front end supplies a one-cycle strobe for each finished frame, together with the captured first bit of that frame. The rest of the chip acts on the fail-safe request.

Top module: `spi_toggle_watchdog`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `failsafe_req` and `wd_running` are both 0.
- R2: While the synchronised wake pin is low, the block sleeps. Both outputs stay 0 and `frame_done` strobes have no effect, however many arrive.
- R3: The wake pin passes through a synchroniser of SYNC_STAGES flops (default 2). When it goes from 0 to 1, `wd_running` rises on the (SYNC_STAGES+1)-th clock edge after the new level is first sampled, and the timeout count starts from zero on that edge. A pin that is already high when `rst_n` is released counts as a rising edge.
- R4: The first frame after arming sets the reference bit. It restarts the timeout whatever its MSB value is, even if that value equals the reference from before the block last slept.
- R5: A frame whose `frame_msb` differs from the reference restarts the timeout and becomes the new reference.
- R6: A frame whose `frame_msb` equals the reference does not restart the timeout.
- R7: `failsafe_req` rises on the TIMEOUT_CYC-th clock edge after the last restart if no restart occurs in between. A restart on exactly that edge prevents the timeout.
- R8: Once `failsafe_req` is 1, it stays 1 and `wd_running` is 0 for as long as the wake pin stays high, and frames are ignored.
- R9: When the wake pin goes low, `failsafe_req` clears within SYNC_STAGES+1 edges. A later rising edge re-arms the block with no reference bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| wake_pin | input | 1 | Asynchronous wake/reset pin level; its rising edge arms the watchdog |
| frame_done | input | 1 | One-cycle strobe when a 16-bit frame has been received |
| frame_msb | input | 1 | First (most significant) bit of the frame just completed |
| failsafe_req | output | 1 | Fail-safe request, held until the wake pin goes low |
| wd_running | output | 1 | Watchdog armed and counting |

## Verification
Some properties are checked by assertions on every cycle:
- the two outputs are never high together;
- the fail-safe request holds while the pin stays high;
- a low synchronised pin forces both outputs low on the next edge;
- a rising edge arms the block;
- a restart blocks a timeout on the next edge;
- the request rises only after exactly TIMEOUT_CYC quiet cycles, counted independently in the checker.

Other behaviour depends on a sequence of frames, so only the bench scenarios can show it. These are: the reference bit being taken from the first frame, same-bit frames failing to restart the count, a restart landing on the final cycle, and a fresh reference after re-arming.

// File: rtl/stw_pkg.sv
// Package: shared types for the SPI toggle-bit watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package stw_pkg;
    typedef enum logic [1:0] {
        WD_SLEEP  = 2'd0,
        WD_ACTIVE = 2'd1,
        WD_FAILED = 2'd2
    } wd_state_t;
endpackage

// File: rtl/stw_pin_sync.sv
// Module: stw_pin_sync
// Brings the asynchronous wake pin into the clock domain and flags its rising edges.
// Assumes: SYNC_STAGES >= 2. All flops clear on reset, so a pin that is high
// when reset is released appears as a rising edge.
module stw_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_lvl,
    output logic pin_rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl_d;

    // Purpose: metastability chain for the pin
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
    end

    // Purpose: delayed copy of the synchronised level, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= sync_q[SYNC_STAGES-1];
    end

    assign pin_lvl  = sync_q[SYNC_STAGES-1];
    assign pin_rise = pin_lvl & ~lvl_d;
endmodule

// File: rtl/stw_toggle_track.sv
// Module: stw_toggle_track
// Holds the reference watch bit and raises a kick for each frame that restarts
// the timeout: the first frame after clearing, or a frame whose bit has flipped.
// Assumes: frame_done is a single-cycle strobe; clear has priority over frames.
module stw_toggle_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    input  logic frame_done,
    input  logic frame_msb,
    output logic kick
);
    logic ref_bit;
    logic have_ref;

    assign kick = active & ~clear & frame_done & (~have_ref | (frame_msb != ref_bit));

    // Purpose: record the reference bit on each kick, forget it on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ref_bit  <= 1'b0;
            have_ref <= 1'b0;
        end else if (kick) begin
            ref_bit  <= frame_msb;
            have_ref <= 1'b1;
        end
    end
endmodule

// File: rtl/stw_timer.sv
// Module: stw_timer
// Counts quiet cycles while the watchdog runs. Expire is raised when the count
// sits at its last value with no restart in the same cycle.
// Assumes: TIMEOUT_CYC >= 2; restart overrides expiry.
module stw_timer #(
    parameter int TIMEOUT_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign expire = run & ~restart & (cnt == LAST);

    // Purpose: advance the quiet-cycle count, holding at the last value
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) cnt <= '0;
        else if (cnt != LAST)          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_toggle_watchdog.sv
// Module: spi_toggle_watchdog (top)
// Sleeps while the wake pin is low, arms on its rising edge, and requests
// fail-safe when the frame watch bit stops alternating for TIMEOUT_CYC cycles.
// Assumes: frame_done/frame_msb come from the serial front end in this clock
// domain; wake_pin is asynchronous.
module spi_toggle_watchdog #(
    parameter int TIMEOUT_CYC = 50000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_pin,
    input  logic frame_done,
    input  logic frame_msb,
    output logic failsafe_req,
    output logic wd_running
);
    import stw_pkg::*;

    wd_state_t state, state_nx;
    logic      pin_lvl, pin_rise, kick, expire, asleep;

    stw_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(wake_pin),
        .pin_lvl(pin_lvl), .pin_rise(pin_rise)
    );

    assign asleep     = (state == WD_SLEEP);
    assign wd_running = (state == WD_ACTIVE);
    assign failsafe_req = (state == WD_FAILED);

    stw_toggle_track u_track (
        .clk(clk), .rst_n(rst_n), .clear(asleep | pin_rise),
        .active(wd_running), .frame_done(frame_done), .frame_msb(frame_msb),
        .kick(kick)
    );

    stw_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(wd_running),
        .restart(kick | pin_rise), .expire(expire)
    );

    // Purpose: next-state decision; a low pin always forces sleep
    always_comb begin
        state_nx = state;
        if (!pin_lvl) begin
            state_nx = WD_SLEEP;
        end else begin
            case (state)
                WD_SLEEP:  if (pin_rise) state_nx = WD_ACTIVE;
                WD_ACTIVE: if (expire)   state_nx = WD_FAILED;
                WD_FAILED: state_nx = WD_FAILED;
                default:   state_nx = WD_SLEEP;
            endcase
        end
    end

    // Purpose: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WD_SLEEP;
        else        state <= state_nx;
    end
endmodule

// File: rtl/stw_checker.sv
// Module: stw_checker
// Assertion set for spi_toggle_watchdog, attached with bind below. Keeps its
// own count of quiet cycles to check the timeout length.
// Assumes: kick and pin_rise are the restart sources inside the top.
module stw_checker #(
    parameter int TIMEOUT_CYC = 50000
) (
    input logic clk,
    input logic rst_n,
    input logic pin_lvl,
    input logic pin_rise,
    input logic kick,
    input logic wd_running,
    input logic failsafe_req
);
    logic [31:0] quiet;

    // Purpose: independent count of cycles since the last restart
    always_ff @(posedge clk) begin
        if (!rst_n || kick || pin_rise) quiet <= '0;
        else if (wd_running)            quiet <= quiet + 1;
    end

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(failsafe_req && wd_running));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (failsafe_req && pin_lvl) |=> failsafe_req);

    p_sleep_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_lvl |=> (!wd_running && !failsafe_req));

    p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> wd_running);

    p_kick_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !failsafe_req);

    p_timeout_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(failsafe_req) |-> ($past(wd_running) && $past(quiet) == 32'(TIMEOUT_CYC - 1)));
endmodule

bind spi_toggle_watchdog stw_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_rise(pin_rise),
    .kick(kick), .wd_running(wd_running), .failsafe_req(failsafe_req)
);

// File: tb/test_spi_toggle_watchdog.sv
module test_spi_toggle_watchdog;
    localparam int TO = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake_pin = 1'b0;
    logic frame_done = 1'b0;
    logic frame_msb = 1'b0;
    logic failsafe_req, wd_running;
    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    spi_toggle_watchdog #(.TIMEOUT_CYC(TO), .SYNC_STAGES(2)) i_spi_toggle_watchdog (
        .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .frame_done(frame_done),
        .frame_msb(frame_msb), .failsafe_req(failsafe_req), .wd_running(wd_running)
    );

    // vector: frame bit, cycles to wait after the frame edge, expected fail, expected run
    typedef struct packed {
        logic       bitv;
        logic [7:0] wait_cyc;
        logic       exp_fail;
        logic       exp_run;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 8'd10, 1'b0, 1'b1},  // R4 first frame sets reference
        '{1'b0, 8'd19, 1'b0, 1'b1},  // R5 flip, sample one cycle before expiry
        '{1'b1, 8'd5,  1'b0, 1'b1},  // R7 flip on the final cycle prevents timeout
        '{1'b1, 8'd5,  1'b0, 1'b1},  // R6 same bit, no restart
        '{1'b1, 8'd8,  1'b1, 1'b0},  // R6 R7 expiry 20 edges after last flip
        '{1'b0, 8'd3,  1'b1, 1'b0}   // R8 flip ignored once failed
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_frame(input logic b);
        frame_done = 1'b1;
        frame_msb  = b;
        tick(1);
        frame_done = 1'b0;
    endtask

    task automatic check(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0b expected=%0b", req, got, exp);
        end
    endtask

    task automatic arm();
        wake_pin = 1'b1;
        tick(3);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(3);
        check("R1 fail in reset", failsafe_req, 1'b0);
        check("R1 run in reset", wd_running, 1'b0);
        rst_n = 1'b1;
        tick(1);
        check("R1 run after release", wd_running, 1'b0);

        // R2: frames while pin low are ignored
        for (int i = 0; i < 5; i++) begin
            send_frame(i[0]);
            tick(2);
        end
        tick(30);
        check("R2 run while asleep", wd_running, 1'b0);
        check("R2 fail while asleep", failsafe_req, 1'b0);

        // R3: arming latency
        wake_pin = 1'b1;
        tick(2);
        check("R3 not yet running", wd_running, 1'b0);
        tick(1);
        check("R3 running", wd_running, 1'b1);

        // vector table walk
        for (int v = 0; v < 6; v++) begin
            send_frame(VECS[v].bitv);
            tick(int'(VECS[v].wait_cyc));
            check($sformatf("R7 vec%0d fail", v), failsafe_req, VECS[v].exp_fail);
            check($sformatf("R8 vec%0d run", v), wd_running, VECS[v].exp_run);
        end

        tick(30);
        check("R8 sticky", failsafe_req, 1'b1);

        // R9: pin low clears
        wake_pin = 1'b0;
        tick(2);
        check("R9 fail before sync", failsafe_req, 1'b1);
        tick(1);
        check("R9 fail cleared", failsafe_req, 1'b0);
        tick(5);

        // R4/R9: re-arm, first frame restarts even with same bit as old reference
        arm();
        check("R9 rearmed", wd_running, 1'b1);
        tick(15);
        send_frame(1'b1);
        tick(18);
        check("R4 first frame restarted", failsafe_req, 1'b0);
        tick(1);
        check("R7 edge before expiry", failsafe_req, 1'b0);
        tick(1);
        check("R7 expiry after first frame", failsafe_req, 1'b1);

        // R7: no frames at all after arming
        wake_pin = 1'b0;
        tick(6);
        arm();
        tick(19);
        check("R7 no frame, before expiry", failsafe_req, 1'b0);
        tick(1);
        check("R7 no frame, expiry", failsafe_req, 1'b1);

        // R1: system reset mid-operation
        rst_n = 1'b0;
        tick(2);
        check("R1 reset clears fail", failsafe_req, 1'b0);
        check("R1 reset clears run", wd_running, 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule